// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block switches two groups of clock outputs on and off from active-low stop requests that may arrive at any time. A fast group and a slow group each have their own source clock. A group carries its stop request and its per-output enable bits through a two-flop synchronizer clocked by that group's source clock. The gate for each output is a register updated on the falling edge of the source clock, and the output is the source clock ANDed with that register. An output therefore stops only in the low state and restarts with a full-width first high phase.

Once a group has restarted, it stays enabled for a minimum number of its own cycles before a new stop request can take effect. This is 100 cycles for the fast group and 10 for the slow group. One output in each group is exempt from the stop request: the top lane of the fast group and lane 0 of the slow group, which runs freely. Exempt lanes still obey their enable bit.

A mode input is captured on the first rising edge after reset. Stop requests are acted on only when the captured value is 0. When it is 1, the stop inputs are ignored until the next reset.

Top module: `clk_stop_gate`

## Requirements
- R1: While rst_n is low, every output is low. After reset, with all enable bits at 1 and no stop request, every output follows its source clock.
- R2: When a stop request (stop input driven to 0) is applied between two rising edges of a non-exempt lane's source clock, that lane still pulses on the first two rising edges that follow. It is low from the third rising edge on.
- R3: While a group is stopped, its non-exempt outputs are held at logic 0 and do not switch.
- R4: After the stop input returns to 1, non-exempt outputs stay low for the next two rising edges. The first high phase begins on the third rising edge and lasts the full high time of the source clock.
- R5: After a restart, the fast group delivers exactly FAST_MIN_RUN (100) pulses before a pending stop takes effect. Directly after reset no minimum window applies.
- R6: After a restart, the slow group delivers exactly SLOW_MIN_RUN (10) pulses before a pending stop takes effect.
- R7: Exempt lanes (fast lane N_FAST-1 and slow lane 0) keep toggling while their group's stop request is active.
- R8: When an enable bit is set to 0, that lane (exempt lanes included) is held low from the third rising edge after the change. The other lanes are not affected. When the bit is set back to 1, the lane resumes with the same latency and a full first pulse.
- R9: mode_sel is captured on the first rising edge of each group's clock after reset. With a captured 1, stop inputs have no effect. With a captured 0, they are honoured. Later changes to mode_sel have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Source clock of the fast group |
| clk_slow | input | 1 | Source clock of the slow group |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_stop_n | input | 1 | Asynchronous active-low stop request, fast group |
| slow_stop_n | input | 1 | Asynchronous active-low stop request, slow group |
| mode_sel | input | 1 | 0 = honour stop requests, 1 = ignore them; captured after reset |
| fast_en | input | N_FAST | Per-lane enable bits of the fast group (1 = run) |
| slow_en | input | N_SLOW | Per-lane enable bits of the slow group (1 = run) |
| fast_clk_out | output | N_FAST | Gated clocks of the fast group |
| slow_clk_out | output | N_SLOW | Gated clocks of the slow group |

## Verification
Each stop, release or enable change passes through two rising-edge flops and one falling-edge gate register. Its effect therefore appears on the third rising edge after a stimulus that is applied between edges. A pending stop after a restart appears one rising edge after the last pulse of the minimum window. The bench drives every stimulus a few nanoseconds after a rising edge of the clock concerned. It then samples outputs inside the high phase that follows each later rising edge, counting edges from the first one after the stimulus. This lets it check exact pulse counts and the position of the first and last pulse. For restarts it also samples twice within the first high phase to confirm the pulse has full width.

// File: rtl/csg_pkg.sv
`timescale 1ns/1ps
package csg_pkg;

  typedef enum logic {
    MODE_HONOUR = 1'b0,
    MODE_IGNORE = 1'b1
  } csg_mode_e;

  // Width of the minimum-window counter, which must hold min_run-1.
  function automatic int csg_cnt_w(input int min_run);
    return (min_run > 2) ? $clog2(min_run) : 1;
  endfunction

  // Next run state: a running group may stop only once its window has closed.
  function automatic logic csg_run_next(input logic run, input logic win_open,
                                        input logic stop_req);
    if (run) return !(stop_req && !win_open);
    return !stop_req;
  endfunction

  // Gate value of a lane: the enable bit always applies; exempt lanes ignore run.
  function automatic logic csg_gate(input logic en, input logic exempt, input logic run);
    return en & (exempt | run);
  endfunction

endpackage

// File: rtl/csg_sync.sv
`timescale 1ns/1ps
module csg_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/csg_window.sv
`timescale 1ns/1ps
module csg_window #(
  parameter int MIN_RUN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  output logic run_q,
  output logic run_nxt
);
  import csg_pkg::*;

  localparam int CW = csg_cnt_w(MIN_RUN);
  localparam logic [CW-1:0] LOAD = CW'(MIN_RUN - 1);

  logic [CW-1:0] cnt_q;
  logic          win_open;
  logic          evt_start;

  assign win_open  = (cnt_q != '0);
  assign run_nxt   = csg_run_next(run_q, win_open, stop_req);
  assign evt_start = !run_q && run_nxt;

  // Run state and window counter change while the source clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      run_q <= run_nxt;
      if (evt_start)
        cnt_q <= LOAD;
      else if (run_q && win_open)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_MIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> ($past(cnt_q) == '0)); // R5, R6
  AST_STOP_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> stop_req); // R2
  AST_START_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> !stop_req); // R4

endmodule

// File: rtl/csg_lane.sv
`timescale 1ns/1ps
module csg_lane #(
  parameter logic EXEMPT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic run_nxt,
  input  logic run_q,
  output logic clk_out
);
  import csg_pkg::*;

  logic gate_q;

  // The gate changes only on the falling edge, so the AND never chops a high phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= csg_gate(en_s, EXEMPT, run_nxt);
  end

  assign clk_out = clk & gate_q;

  AST_RISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> en_s); // R8

  if (EXEMPT) begin : g_exempt
    AST_EXEMPT_FALL_BY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_q) |-> !en_s); // R7
  end else begin : g_gated
    AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> !gate_q); // R3
  end

endmodule

// File: rtl/csg_group.sv
`timescale 1ns/1ps
module csg_group #(
  parameter int N_OUT = 4,
  parameter int MIN_RUN = 10,
  parameter logic [N_OUT-1:0] EXEMPT = '0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_n,
  input  logic             mode_sel,
  input  logic [N_OUT-1:0] en,
  output logic [N_OUT-1:0] clk_out
);
  import csg_pkg::*;

  localparam int SW = N_OUT + 1;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {N_OUT{1'b0}}};

  csg_mode_e        mode_q;
  logic             mode_done;
  logic [SW-1:0]    sync_q;
  logic             stop_s;
  logic [N_OUT-1:0] en_s;
  logic             honour;
  logic             stop_req;
  logic             run_q;
  logic             run_nxt;

  // Mode is captured once, on the first rising edge after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_HONOUR;
      mode_done <= 1'b0;
    end else if (!mode_done) begin
      mode_q    <= csg_mode_e'(mode_sel);
      mode_done <= 1'b1;
    end
  end

  csg_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({stop_n, en}),
    .q    (sync_q)
  );

  assign stop_s   = sync_q[N_OUT];
  assign en_s     = sync_q[N_OUT-1:0];
  assign honour   = (mode_q == MODE_HONOUR);
  assign stop_req = honour && !stop_s;

  csg_window #(.MIN_RUN(MIN_RUN)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .stop_req(stop_req),
    .run_q   (run_q),
    .run_nxt (run_nxt)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_lane
    csg_lane #(.EXEMPT(EXEMPT[i])) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_s   (en_s[i]),
      .run_nxt(run_nxt),
      .run_q  (run_q),
      .clk_out(clk_out[i])
    );
  end

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    mode_done |=> $stable(mode_q)); // R9
  AST_IGNORE_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_done && mode_q == MODE_IGNORE) |-> run_q); // R9

endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
  parameter int N_FAST = 4,
  parameter int N_SLOW = 6,
  parameter int FAST_MIN_RUN = 100,
  parameter int SLOW_MIN_RUN = 10,
  parameter logic [N_FAST-1:0] FAST_EXEMPT = {1'b1, {(N_FAST-1){1'b0}}},
  parameter logic [N_SLOW-1:0] SLOW_EXEMPT = {{(N_SLOW-1){1'b0}}, 1'b1},
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_fast,
  input  logic              clk_slow,
  input  logic              rst_n,
  input  logic              fast_stop_n,
  input  logic              slow_stop_n,
  input  logic              mode_sel,
  input  logic [N_FAST-1:0] fast_en,
  input  logic [N_SLOW-1:0] slow_en,
  output logic [N_FAST-1:0] fast_clk_out,
  output logic [N_SLOW-1:0] slow_clk_out
);

  csg_group #(
    .N_OUT(N_FAST), .MIN_RUN(FAST_MIN_RUN), .EXEMPT(FAST_EXEMPT), .SYNC_STAGES(SYNC_STAGES)
  ) u_fast (
    .clk     (clk_fast),
    .rst_n   (rst_n),
    .stop_n  (fast_stop_n),
    .mode_sel(mode_sel),
    .en      (fast_en),
    .clk_out (fast_clk_out)
  );

  csg_group #(
    .N_OUT(N_SLOW), .MIN_RUN(SLOW_MIN_RUN), .EXEMPT(SLOW_EXEMPT), .SYNC_STAGES(SYNC_STAGES)
  ) u_slow (
    .clk     (clk_slow),
    .rst_n   (rst_n),
    .stop_n  (slow_stop_n),
    .mode_sel(mode_sel),
    .en      (slow_en),
    .clk_out (slow_clk_out)
  );

endmodule

// File: tb/sim_clk_stop_gate.sv
`timescale 1ns/1ps
module sim_clk_stop_gate;

  localparam int NF = 4;
  localparam int NS = 6;
  localparam int MF = 100;
  localparam int MS = 10;

  logic clk_fast = 1'b0;
  logic clk_slow = 1'b0;
  logic rst_n = 1'b0;
  logic fast_stop_n = 1'b1;
  logic slow_stop_n = 1'b1;
  logic mode_sel = 1'b0;
  logic [NF-1:0] fast_en = '1;
  logic [NS-1:0] slow_en = '1;
  logic [NF-1:0] fast_clk_out;
  logic [NS-1:0] slow_clk_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_fast = ~clk_fast;
  always #12 clk_slow = ~clk_slow;

  clk_stop_gate u0 (
    .clk_fast(clk_fast), .clk_slow(clk_slow), .rst_n(rst_n),
    .fast_stop_n(fast_stop_n), .slow_stop_n(slow_stop_n), .mode_sel(mode_sel),
    .fast_en(fast_en), .slow_en(slow_en),
    .fast_clk_out(fast_clk_out), .slow_clk_out(slow_clk_out)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic out_of(input bit grp, input int lane);
    return grp ? slow_clk_out[lane] : fast_clk_out[lane];
  endfunction

  task automatic edge_of(input bit grp);
    if (grp) @(posedge clk_slow);
    else     @(posedge clk_fast);
  endtask

  task automatic set_stop(input bit grp, input logic val);
    edge_of(grp);
    if (grp) begin #5; slow_stop_n = val; end
    else     begin #3; fast_stop_n = val; end
  endtask

  // Counts rising edges at which the lane is high, sampled inside the high phase.
  task automatic count_hi(input bit grp, input int lane, input int n, output int hits);
    hits = 0;
    for (int k = 0; k < n; k++) begin
      edge_of(grp);
      if (grp) #3; else #2;
      if (out_of(grp, lane)) hits++;
    end
  endtask

  task automatic t_reset();
    int h;
    for (int k = 0; k < 4; k++) begin
      edge_of(1'b1);
      #3;
      check(fast_clk_out == '0 && slow_clk_out == '0, "R1", "outputs low in reset",
            int'(fast_clk_out) + int'(slow_clk_out), 0);
    end
    edge_of(1'b0);
    #3 rst_n = 1'b1;
    for (int k = 0; k < 4; k++) edge_of(1'b1);
    for (int l = 0; l < NF; l++) begin
      count_hi(1'b0, l, 8, h);
      check(h == 8, "R1", "fast lane runs after reset", h, 8);
    end
    for (int l = 0; l < NS; l++) begin
      count_hi(1'b1, l, 8, h);
      check(h == 8, "R1", "slow lane runs after reset", h, 8);
    end
  endtask

  task automatic t_stop(input bit grp, input int lane, input int ex_lane);
    int h;
    set_stop(grp, 1'b0);
    count_hi(grp, lane, 10, h);
    check(h == 2, "R2", "pulses after stop request", h, 2);
    count_hi(grp, lane, 20, h);
    check(h == 0, "R3", "held low while stopped", h, 0);
    count_hi(grp, ex_lane, 12, h);
    check(h == 12, "R7", "exempt lane keeps running", h, 12);
  endtask

  // Release, then request a new stop right away: the window sets the pulse count.
  task automatic t_restart(input bit grp, input int lane, input int m, input string rq);
    int h;
    logic a;
    logic b;
    h = 0;
    a = 1'b0;
    set_stop(grp, 1'b1);
    for (int k = 0; k < m + 10; k++) begin
      edge_of(grp);
      #1 a = out_of(grp, lane);
      if (grp) #5; else #2;
      b = out_of(grp, lane);
      if (k < 2) check(!a && !b, "R4", "low before restart", int'(a) + int'(b), 0);
      if (k == 2) begin
        check(a && b, "R4", "full first high phase", int'(a) + int'(b), 2);
        if (grp) slow_stop_n = 1'b0; else fast_stop_n = 1'b0;
      end
      if (a) h++;
    end
    check(h == m, rq, "pulses in minimum window", h, m);
    check(!a, "R3", "low after window closes", int'(a), 0);
  endtask

  task automatic t_enable();
    int h;
    set_stop(1'b1, 1'b1);
    for (int k = 0; k < 16; k++) edge_of(1'b1);
    edge_of(1'b1);
    #5 slow_en[2] = 1'b0;
    count_hi(1'b1, 2, 10, h);
    check(h == 2, "R8", "disabled lane stops", h, 2);
    count_hi(1'b1, 3, 10, h);
    check(h == 10, "R8", "neighbour lane unaffected", h, 10);
    edge_of(1'b1);
    #5 slow_en[0] = 1'b0;
    count_hi(1'b1, 0, 10, h);
    check(h == 2, "R8", "exempt lane obeys enable", h, 2);
    count_hi(1'b1, 0, 10, h);
    check(h == 0, "R8", "exempt lane held low", h, 0);
    edge_of(1'b1);
    #5 slow_en = '1;
    count_hi(1'b1, 2, 10, h);
    check(h == 8, "R8", "lane resumes after enable", h, 8);
  endtask

  task automatic t_mode();
    int h;
    edge_of(1'b0);
    #3;
    rst_n = 1'b0;
    mode_sel = 1'b1;
    fast_stop_n = 1'b0;
    slow_stop_n = 1'b0;
    #50 rst_n = 1'b1;
    for (int k = 0; k < 8; k++) edge_of(1'b0);
    mode_sel = 1'b0;
    for (int k = 0; k < 4; k++) edge_of(1'b1);
    count_hi(1'b0, 0, 20, h);
    check(h == 20, "R9", "fast ignores stop when captured 1", h, 20);
    count_hi(1'b1, 1, 20, h);
    check(h == 20, "R9", "slow ignores stop when captured 1", h, 20);
    edge_of(1'b0);
    #3 rst_n = 1'b0;
    #50 rst_n = 1'b1;
    for (int k = 0; k < 4; k++) edge_of(1'b1);
    count_hi(1'b0, 0, 20, h);
    check(h == 0, "R9", "stop honoured when captured 0", h, 0);
    count_hi(1'b0, NF - 1, 20, h);
    check(h == 20, "R7", "exempt fast lane after reset", h, 20);
    fast_stop_n = 1'b1;
    slow_stop_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_stop(1'b0, 0, NF - 1);
    t_restart(1'b0, 0, MF, "R5");
    t_stop(1'b1, 1, 0);
    t_restart(1'b1, 1, MS, "R6");
    t_enable();
    t_mode();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule